// File: doc/BRIEF.md
# Fixed-Price Drink Vending Controller

This block is the control core of a drink dispenser. It accepts one coin type and sells every drink at the same price, which is set by the parameter `PRICE_COINS` (three coins by default). It counts the coins inserted and allows a drink to be released only after full payment. A refund request returns whatever is held. A selected drink whose sold-out sensor is active is refused, and the coins stay held.

The coin trigger, refund button and drink-select buttons are sampled on the clock and reduced to rising edges, so a held button acts once. The edges are collapsed into one prioritized event code. A constant lookup table, addressed by the current coin count joined with that event code, supplies the next coin count and the release and refund requests. The two output latch signals are registered and pulse for a single cycle.

Top module: `vend_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with no input activity, all release outputs and the refund output are low and the coin count is zero.
- R2: Each rising edge of `coin_pulse` while fewer than `PRICE_COINS` coins are held adds one coin and produces no output pulse.
- R3: An input held high for several cycles counts as a single event. Only a low-to-high transition of a button or trigger is acted on.
- R4: Drink-select edges while fewer than `PRICE_COINS` coins are held release nothing and leave the count unchanged.
- R5: A select edge for drink i at full payment, with drink i not sold out, drives bit i of `drink_release` high for exactly one cycle and clears the count. Bit i belongs to drink i. At most one release bit is ever high.
- R6: A select edge for a drink whose `sold_out` bit is high releases nothing and keeps the coins held.
- R7: A refund edge with coins held pulses `coin_refund` for one cycle and clears the count. A refund edge with no coins held and no coin edge produces no pulse.
- R8: A coin edge when `PRICE_COINS` coins are already held pulses `coin_refund` at once, and the count stays at full.
- R9: Events in the same cycle are ranked refund, then coin, then selection. A refund together with a coin edge returns everything with one pulse and clears the count, even when the count was zero.
- R10: Among simultaneous select edges, the lowest-numbered drink is the only candidate. If that drink is sold out, nothing is released.
- R11: All outputs are registered. They appear in the cycle after the clock edge that samples the triggering input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| coin_pulse | input | 1 | Coin trigger, one rising edge per coin |
| refund_btn | input | 1 | Refund request button |
| drink_sel | input | NUM_DRINKS | Drink-select buttons, bit i is drink i |
| sold_out | input | NUM_DRINKS | Sold-out sensor levels, bit i is drink i |
| drink_release | output | NUM_DRINKS | One-cycle release latch pulse, bit i is drink i |
| coin_refund | output | 1 | One-cycle coin return latch pulse |

## Verification
Every result is due exactly one clock after the rising edge that samples the stimulus. The edge detector and the lookup table are combinational in front of the output and count registers. The bench therefore drives inputs on a falling edge and compares both outputs at the next falling edge, against a reference model that mirrors the edge detection, the ranking and the coin count. The coin count is not a port, so a wrong count shows up later as a missing or extra release or refund pulse. The long random run makes such a divergence surface on the outputs.

// File: rtl/vend_pkg.sv
package vend_pkg;

  localparam int unsigned EV_W = 3;

  // Prioritized event applied to the coin counter in one cycle
  typedef enum logic [EV_W-1:0] {
    EV_NONE        = 3'd0,
    EV_COIN        = 3'd1,
    EV_REFUND      = 3'd2,
    EV_REFUND_COIN = 3'd3,
    EV_SELECT      = 3'd4,
    EV_SELECT_SOLD = 3'd5
  } vend_ev_e;

endpackage

// File: rtl/vend_rst_sync.sv
module vend_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/vend_edge_det.sv
module vend_edge_det #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_i,
  output logic [WIDTH-1:0] rise_o
);

  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] prev_d;

  always_comb begin
    prev_d = level_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  assign rise_o = level_i & ~prev_q;

endmodule

// File: rtl/vend_event_enc.sv
module vend_event_enc
  import vend_pkg::*;
#(
  parameter int unsigned NUM_DRINKS = 10,
  localparam int unsigned IDX_W = (NUM_DRINKS > 1) ? $clog2(NUM_DRINKS) : 1
) (
  input  logic                  coin_rise,
  input  logic                  refund_rise,
  input  logic [NUM_DRINKS-1:0] sel_rise,
  input  logic [NUM_DRINKS-1:0] sold_out,
  output vend_ev_e              ev_o,
  output logic [IDX_W-1:0]      idx_o
);

  logic             pick_found;
  logic [IDX_W-1:0] pick_idx;

  // lowest-numbered select edge wins
  always_comb begin
    pick_found = 1'b0;
    pick_idx   = '0;
    for (int i = NUM_DRINKS - 1; i >= 0; i--) begin
      if (sel_rise[i]) begin
        pick_found = 1'b1;
        pick_idx   = IDX_W'(i);
      end
    end
  end

  // refund outranks coin, coin outranks selection
  always_comb begin
    ev_o = EV_NONE;
    if (refund_rise) begin
      ev_o = coin_rise ? EV_REFUND_COIN : EV_REFUND;
    end else if (coin_rise) begin
      ev_o = EV_COIN;
    end else if (pick_found) begin
      ev_o = sold_out[pick_idx] ? EV_SELECT_SOLD : EV_SELECT;
    end
  end

  assign idx_o = pick_idx;

endmodule

// File: rtl/vend_rom.sv
module vend_rom
  import vend_pkg::*;
#(
  parameter int unsigned SW          = 2,
  parameter int unsigned PRICE_COINS = 3,
  localparam int unsigned AW    = SW + EV_W,
  localparam int unsigned DW    = SW + 2,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] data_o
);

  // data word: {next_count, release_req, refund_req}
  function automatic logic [DW-1:0] rom_word(input int unsigned a);
    logic [SW-1:0]   st;
    logic [EV_W-1:0] ev;
    logic [SW-1:0]   nxt;
    logic            rel;
    logic            rfd;
    st  = SW'(a >> EV_W);
    ev  = EV_W'(a);
    nxt = st;
    rel = 1'b0;
    rfd = 1'b0;
    if (32'(st) > PRICE_COINS) begin
      nxt = '0;
    end else begin
      case (vend_ev_e'(ev))
        EV_COIN: begin
          if (32'(st) < PRICE_COINS) nxt = st + 1'b1;
          else                       rfd = 1'b1;
        end
        EV_REFUND: begin
          nxt = '0;
          rfd = (st != '0);
        end
        EV_REFUND_COIN: begin
          nxt = '0;
          rfd = 1'b1;
        end
        EV_SELECT: begin
          if (32'(st) == PRICE_COINS) begin
            nxt = '0;
            rel = 1'b1;
          end
        end
        default: nxt = st;
      endcase
    end
    return {nxt, rel, rfd};
  endfunction

  logic [DW-1:0] table_w [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_entry
    assign table_w[a] = rom_word(a);
  end

  assign data_o = table_w[addr_i];

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
#(
  parameter int unsigned NUM_DRINKS  = 10,
  parameter int unsigned PRICE_COINS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  coin_pulse,
  input  logic                  refund_btn,
  input  logic [NUM_DRINKS-1:0] drink_sel,
  input  logic [NUM_DRINKS-1:0] sold_out,
  output logic [NUM_DRINKS-1:0] drink_release,
  output logic                  coin_refund
);

  localparam int unsigned SW    = $clog2(PRICE_COINS + 1);
  localparam int unsigned IDX_W = (NUM_DRINKS > 1) ? $clog2(NUM_DRINKS) : 1;
  localparam int unsigned IN_W  = NUM_DRINKS + 2;
  localparam int unsigned AW    = SW + EV_W;
  localparam int unsigned DW    = SW + 2;

  logic srst_n;

  vend_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  logic [IN_W-1:0] in_rise;

  vend_edge_det #(.WIDTH(IN_W)) u_edge (
    .clk     (clk),
    .rst_n   (srst_n),
    .level_i ({drink_sel, refund_btn, coin_pulse}),
    .rise_o  (in_rise)
  );

  vend_ev_e         ev;
  logic [IDX_W-1:0] drink_idx;

  vend_event_enc #(.NUM_DRINKS(NUM_DRINKS)) u_enc (
    .coin_rise   (in_rise[0]),
    .refund_rise (in_rise[1]),
    .sel_rise    (in_rise[IN_W-1:2]),
    .sold_out    (sold_out),
    .ev_o        (ev),
    .idx_o       (drink_idx)
  );

  logic [SW-1:0] coins_q;
  logic [DW-1:0] rom_data;

  vend_rom #(.SW(SW), .PRICE_COINS(PRICE_COINS)) u_rom (
    .addr_i ({coins_q, ev}),
    .data_o (rom_data)
  );

  logic [SW-1:0]         coins_d;
  logic                  coins_en;
  logic                  rel_req;
  logic [NUM_DRINKS-1:0] release_d;
  logic                  refund_d;

  assign coins_d  = rom_data[DW-1:2];
  assign rel_req  = rom_data[1];
  assign refund_d = rom_data[0];
  assign coins_en = (ev != EV_NONE);

  for (genvar i = 0; i < NUM_DRINKS; i++) begin : g_rel
    assign release_d[i] = rel_req && (drink_idx == IDX_W'(i));
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)       coins_q <= '0;
    else if (coins_en) coins_q <= coins_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      drink_release <= '0;
      coin_refund   <= 1'b0;
    end else begin
      drink_release <= release_d;
      coin_refund   <= refund_d;
    end
  end

endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk #(
  parameter int unsigned NUM_DRINKS  = 10,
  parameter int unsigned PRICE_COINS = 3,
  parameter int unsigned SW          = 2
) (
  input logic                  clk,
  input logic                  srst_n,
  input logic [SW-1:0]         coins,
  input logic [NUM_DRINKS-1:0] release_v,
  input logic                  refund
);

  // R5
  release_onehot_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0(release_v));

  // R5
  release_paid_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (|release_v) |-> ($past(coins) == SW'(PRICE_COINS) && coins == '0));

  // R5
  release_pulse_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (|release_v) |=> (release_v == '0));

  // R2
  coin_step_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (coins != $past(coins)) |-> (coins == SW'($past(coins) + 1'b1) || coins == '0));

  // R8
  refund_state_chk: assert property (@(posedge clk) disable iff (!srst_n)
    refund |-> (coins == '0 || (coins == SW'(PRICE_COINS) && $past(coins) == SW'(PRICE_COINS))));

  // R9
  refund_release_excl_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !(refund && (|release_v)));

endmodule

bind vend_ctrl vend_ctrl_chk #(
  .NUM_DRINKS  (NUM_DRINKS),
  .PRICE_COINS (PRICE_COINS),
  .SW          (SW)
) u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .coins     (coins_q),
  .release_v (drink_release),
  .refund    (coin_refund)
);

// File: tb/sim_vend_ctrl.sv
`timescale 1ns/1ps
module sim_vend_ctrl;

  localparam int N     = 10;
  localparam int PRICE = 3;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         coin_pulse;
  logic         refund_btn;
  logic [N-1:0] drink_sel;
  logic [N-1:0] sold_out;
  logic [N-1:0] drink_release;
  logic         coin_refund;

  always #2 clk = ~clk;

  vend_ctrl #(.NUM_DRINKS(N), .PRICE_COINS(PRICE)) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .coin_pulse    (coin_pulse),
    .refund_btn    (refund_btn),
    .drink_sel     (drink_sel),
    .sold_out      (sold_out),
    .drink_release (drink_release),
    .coin_refund   (coin_refund)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference model state
  int           m_coins;
  logic         m_pc, m_pr;
  logic [N-1:0] m_ps;

  task automatic check(input string tag, input logic [N-1:0] er, input logic eref);
    n_chk++;
    if (drink_release !== er || coin_refund !== eref) begin
      n_bad++;
      $display("FAIL %s: release=%b refund=%b expected release=%b refund=%b",
               tag, drink_release, coin_refund, er, eref);
    end
  endtask

  function automatic int lowest(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  // called on a falling edge; result checked on the next falling edge (R11)
  task automatic step(input logic c, input logic r, input logic [N-1:0] s, input logic [N-1:0] so);
    logic         ce, re;
    logic [N-1:0] se;
    logic [N-1:0] er;
    logic         eref;
    string        tag;
    int           w;
    coin_pulse = c; refund_btn = r; drink_sel = s; sold_out = so;
    ce = c & ~m_pc; re = r & ~m_pr; se = s & ~m_ps;
    er = '0; eref = 1'b0; tag = "R2";
    if ((c && !ce) || (r && !re) || ((s & ~se) != '0)) tag = "R3";
    if (re) begin
      tag  = ce ? "R9" : "R7";
      eref = (m_coins != 0) || ce;
      m_coins = 0;
    end else if (ce) begin
      if (m_coins < PRICE) m_coins++;
      else begin eref = 1'b1; tag = "R8"; end
      if (se != '0) tag = "R9";
    end else if (se != '0) begin
      w = lowest(se);
      if (m_coins < PRICE) tag = "R4";
      else if (so[w]) tag = "R6";
      else begin er[w] = 1'b1; m_coins = 0; tag = "R5"; end
      if ($countones(se) > 1) tag = "R10";
    end
    m_pc = c; m_pr = r; m_ps = s;
    @(negedge clk);
    check(tag, er, eref);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, '0);
  endtask

  task automatic pay();
    for (int i = 0; i < PRICE; i++) begin
      step(1'b1, 1'b0, '0, '0);
      step(1'b0, 1'b0, '0, '0);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd24680));
    rst_n = 1'b0; coin_pulse = 1'b0; refund_btn = 1'b0; drink_sel = '0; sold_out = '0;
    m_coins = 0; m_pc = 1'b0; m_pr = 1'b0; m_ps = '0;
    repeat (4) @(negedge clk);
    check("R1", '0, 1'b0);
    rst_n = 1'b1;
    idle(4);
    // R1 idle after reset gives nothing
    check("R1", '0, 1'b0);

    // R5 plain sale of drink 4
    pay(); step(1'b0, 1'b0, N'(1) << 4, '0); idle(2);
    // R3 held coin counts once, then two more coins complete payment
    step(1'b1, 1'b0, '0, '0); step(1'b1, 1'b0, '0, '0); step(1'b1, 1'b0, '0, '0); idle(1);
    step(1'b1, 1'b0, '0, '0); idle(1); step(1'b1, 1'b0, '0, '0); idle(1);
    step(1'b0, 1'b0, N'(1) << 9, '0); step(1'b0, 1'b0, N'(1) << 9, '0); idle(1);
    // R4 selection with two coins ignored, third coin then sale of drink 0
    step(1'b1, 1'b0, '0, '0); idle(1); step(1'b1, 1'b0, '0, '0); idle(1);
    step(1'b0, 1'b0, N'(1), '0); idle(1);
    step(1'b1, 1'b0, '0, '0); idle(1); step(1'b0, 1'b0, N'(1), '0); idle(1);
    // R6 sold-out drink keeps coins, other drink then sells
    pay(); step(1'b0, 1'b0, N'(1) << 2, N'(1) << 2); idle(1);
    step(1'b0, 1'b0, N'(1) << 3, N'(1) << 2); idle(1);
    // R8 extra coin returned, count stays full
    pay(); step(1'b1, 1'b0, '0, '0); idle(1); step(1'b0, 1'b0, N'(1) << 1, '0); idle(1);
    // R7 refund with coins, refund with none
    step(1'b1, 1'b0, '0, '0); idle(1); step(1'b0, 1'b1, '0, '0); idle(1);
    step(1'b0, 1'b1, '0, '0); idle(1);
    // R9 refund plus coin at zero coins, coin plus select at full
    step(1'b1, 1'b1, '0, '0); idle(1);
    pay(); step(1'b1, 1'b0, N'(1) << 5, '0); idle(1);
    // R10 simultaneous selections: lowest wins; lowest sold out gives nothing
    step(1'b0, 1'b0, 10'b0001010000, 10'b0000010000); idle(1);
    step(1'b0, 1'b0, 10'b1000100000, '0); idle(2);

    // constrained random phase
    for (int k = 0; k < 3000; k++) begin
      logic         c, r;
      logic [N-1:0] s, so;
      c = ($urandom_range(0, 99) < 30);
      r = ($urandom_range(0, 99) < 4);
      s = '0;
      if ($urandom_range(0, 99) < 20) s[$urandom_range(0, N - 1)] = 1'b1;
      if ($urandom_range(0, 99) < 5)  s = N'($urandom);
      so = '0;
      for (int j = 0; j < N; j++) so[j] = ($urandom_range(0, 99) < 10);
      step(c, r, s, so);
    end
    idle(2);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule